// File: doc/BRIEF.md
# MDIO Management Bus Master

This block lets a host reach the management registers of Ethernet PHYs over a two-wire MDIO bus using Clause 22 framing. The host talks to it through a small 32-bit register bus: a write strobe, a read strobe, a byte address, write data and registered read data. On the line side the block produces the MDC clock and drives the shared MDIO wire through a separate output value, an output enable and an input sample, so the tri-state buffer sits outside.

A read is started by writing the control word with the read flag set; the block sends preamble, start, read opcode, PHY and register numbers, releases the wire for turnaround and shifts in sixteen data bits, which land in the data word. A write is prepared by writing the control word without the read flag and launched by writing the 16-bit value to the data word. While a frame runs the busy flag in the configuration word is set; the host polls it, then checks the read-error flag after reads. Writes to the trigger registers during a frame are dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration, control and data words read 0, `mdc` is low, `mdio_oe` is low and `mdio_o` is high.
- R2: Byte offsets: 0x30 configuration, 0x34 control, 0x38 data, 0x3C a 32-bit storage word read back unchanged. Control holds PHY number in bits 9:5 and register number in bits 4:0 and reads back those fields with all other bits 0; any other offset reads 0. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R3: Configuration bit 31 is a read-only busy flag, 1 from the write that launches a frame until the frame ends and 0 when idle.
- R4: A control write with bit 15 set sends a 64-bit read frame: 32 ones, 01, opcode 10, 5-bit PHY, 5-bit register (MSB first); `mdio_oe` is low from frame bit 46 on, and bits 48..63 are taken from `mdio_i`.
- R5: A control write with bit 15 clear starts no frame; a following write to the data word sends 32 ones, 01, opcode 01, PHY, register, turnaround 10 and the 16 data bits MSB first, all driven.
- R6: After a read frame the data word holds the 16 received bits in bits 15:0 with bits 31:16 zero.
- R7: Configuration bit 1 is set when `mdio_i` is high at turnaround bit 47 of a read, and is cleared when the next read starts.
- R8: Control and data writes that arrive while busy is set change neither register and start no frame.
- R9: MDC toggles every MDC_HALF clock cycles; `mdio_o` changes only right after MDC falls and `mdio_i` is sampled as MDC rises.
- R10: The data word reads back the last value written to it, upper 16 bits zero.
- R11: Configuration bit 6 is stored and read back but does not alter frame contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The bench builds the block with MDC_HALF of 2, so MDC runs at a quarter of the system clock and a whole 64-bit frame lasts about 260 cycles; this makes many full read and write frames, the mid-frame write attempts and the turnaround error path affordable in one run. The default MDC_HALF of 40 gives 2.5 MHz from 200 MHz and is only exercised through elaboration, since frame content does not depend on the divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFS_CFG  = 8'h30;
  localparam logic [BUS_AW-1:0] OFS_CTL  = 8'h34;
  localparam logic [BUS_AW-1:0] OFS_DATA = 8'h38;
  localparam logic [BUS_AW-1:0] OFS_XREG = 8'h3C;

  localparam int BIT_BUSY = 31;
  localparam int BIT_RDERR = 1;
  localparam int BIT_C45 = 6;
  localparam int BIT_RDREQ = 15;

  localparam int FRAME_LEN = 64;
  localparam int TA_FIRST = 46;
  localparam int TA_LAST = 47;
  localparam int DATA_FIRST = 48;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} frm_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_HALF = 40
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;
  logic wrap;

  assign wrap = (cnt == LAST);
  assign rise_tk = wrap && !mdc;
  assign fall_tk = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: MDC only toggles once the half-period counter has run out
  p_mdc_half_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |-> $past(cnt) == LAST);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        is_read_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy_o,
  output logic        done_o,
  output logic        done_rd_o,
  output logic [15:0] rx_o,
  output logic        ta_err_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  frm_state_t state;
  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic rd_q;
  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0] cnt_nx;

  assign frame = {32'hFFFF_FFFF, 2'b01, (is_read_i ? 2'b10 : 2'b01), phy_i, reg_i,
                  (is_read_i ? 18'h3FFFF : {2'b10, wdata_i})};
  assign cnt_nx = cnt + 1'b1;
  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sh <= '0;
      cnt <= '0;
      rd_q <= 1'b0;
      mdio_o <= 1'b1;
      mdio_oe <= 1'b0;
      done_o <= 1'b0;
      done_rd_o <= 1'b0;
      rx_o <= '0;
      ta_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      done_rd_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          sh <= frame;
          rd_q <= is_read_i;
          ta_err_o <= 1'b0;
          state <= ST_ARM;
        end
        ST_ARM: if (fall_tk) begin
          mdio_o <= sh[FRAME_LEN-1];
          mdio_oe <= 1'b1;
          sh <= sh << 1;
          cnt <= '0;
          state <= ST_RUN;
        end
        default: begin
          if (rise_tk && rd_q) begin
            if (cnt == CNT_W'(TA_LAST)) ta_err_o <= mdio_i;
            if (cnt >= CNT_W'(DATA_FIRST)) rx_o <= {rx_o[14:0], mdio_i};
          end
          if (fall_tk) begin
            if (cnt == CNT_LAST) begin
              state <= ST_IDLE;
              mdio_o <= 1'b1;
              mdio_oe <= 1'b0;
              done_o <= 1'b1;
              done_rd_o <= rd_q;
            end else begin
              cnt <= cnt_nx;
              mdio_o <= sh[FRAME_LEN-1];
              sh <= sh << 1;
              mdio_oe <= !rd_q || (cnt_nx < CNT_W'(TA_FIRST));
            end
          end
        end
      endcase
    end
  end

  // R3: the wire is only driven while a frame is in progress
  p_oe_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy_o);
  // R9: output data moves only on the falling MDC edge
  p_out_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $past(fall_tk));
  // R4: master releases the wire from turnaround on during reads
  p_release_read_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && rd_q && cnt >= CNT_W'(TA_FIRST)) |-> !mdio_oe);
  // R8: a new frame is only handed over when the engine is idle
  p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_busy,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [15:0]       rx_i,
  input  logic              ta_err_i,
  output logic              start_o,
  output logic              is_read_o,
  output logic [4:0]        phy_o,
  output logic [4:0]        reg_o,
  output logic [15:0]       data_o
);
  logic ctl_we, data_we, cfg_we, xreg_we;
  logic busy_all;
  logic c45_q, err_q;
  logic [31:0] xreg_q;

  assign busy_all = eng_busy | start_o;
  assign ctl_we  = bus_wr && (bus_addr == OFS_CTL);
  assign data_we = bus_wr && (bus_addr == OFS_DATA);
  assign cfg_we  = bus_wr && (bus_addr == OFS_CFG);
  assign xreg_we = bus_wr && (bus_addr == OFS_XREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= 1'b0;
      is_read_o <= 1'b0;
      phy_o <= '0;
      reg_o <= '0;
      data_o <= '0;
      c45_q <= 1'b0;
      err_q <= 1'b0;
      xreg_q <= '0;
    end else begin
      start_o <= 1'b0;
      if (cfg_we) c45_q <= bus_wdata[BIT_C45];
      if (xreg_we) xreg_q <= bus_wdata;
      if (ctl_we && !busy_all) begin
        phy_o <= bus_wdata[9:5];
        reg_o <= bus_wdata[4:0];
        if (bus_wdata[BIT_RDREQ]) begin
          start_o <= 1'b1;
          is_read_o <= 1'b1;
          err_q <= 1'b0;
        end
      end else if (data_we && !busy_all) begin
        data_o <= bus_wdata[15:0];
        start_o <= 1'b1;
        is_read_o <= 1'b0;
      end
      if (done_i && done_rd_i) begin
        data_o <= rx_i;
        err_q <= ta_err_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CFG: begin
          bus_rdata <= '0;
          bus_rdata[BIT_BUSY] <= busy_all;
          bus_rdata[BIT_C45] <= c45_q;
          bus_rdata[BIT_RDERR] <= err_q;
        end
        OFS_CTL:  bus_rdata <= {22'd0, phy_o, reg_o};
        OFS_DATA: bus_rdata <= {16'd0, data_o};
        OFS_XREG: bus_rdata <= xreg_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R8: control fields hold when a write lands during a frame
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && busy_all) |=> ($stable(phy_o) && $stable(reg_o)));
  // R8: no second launch while one is pending or running
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    busy_all |=> !start_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int MDC_HALF = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic rise_tk, fall_tk;
  logic start, is_read, eng_busy, done, done_rd, ta_err;
  logic [4:0] phy, regn;
  logic [15:0] wdata, rx;

  mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .done_i(done), .done_rd_i(done_rd), .rx_i(rx), .ta_err_i(ta_err),
    .start_o(start), .is_read_o(is_read), .phy_o(phy), .reg_o(regn), .data_o(wdata)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .start_i(start), .is_read_i(is_read), .phy_i(phy),
    .reg_i(regn), .wdata_i(wdata), .rise_tk(rise_tk), .fall_tk(fall_tk),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy_o(eng_busy),
    .done_o(done), .done_rd_o(done_rd), .rx_o(rx), .ta_err_o(ta_err)
  );
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 2;
  localparam logic [7:0] A_CFG = 8'h30, A_CTL = 8'h34, A_DAT = 8'h38, A_XR = 8'h3C;
  // {read, phy, reg, write data, phy data, turnaround error}
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 1'b0},
    {1'b1, 5'd1,  5'd2,  16'h0000, 16'h1234, 1'b0},
    {1'b1, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 1'b1},
    {1'b1, 5'd7,  5'd9,  16'h0000, 16'h8001, 1'b0},
    {1'b0, 5'd0,  5'd31, 16'hFFFF, 16'h0000, 1'b0},
    {1'b0, 5'd21, 5'd10, 16'h0001, 16'h0000, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic drv = 0, drv_val = 0;
  int checks = 0, fails = 0;
  int bpos = 0, frames = 0;
  logic [63:0] rec = 0;
  logic phy_rd = 0;
  logic [15:0] phy_data = 0;
  logic phy_err = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  assign mdio_i = drv ? drv_val : (mdio_oe ? mdio_o : 1'b1);

  mdio_master #(.MDC_HALF(HALF)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // line monitor: records each bit of a frame on the rising MDC edge
  always @(posedge mdc) begin
    if (mdio_oe || (bpos >= 46 && bpos < 64)) begin
      rec = {rec[62:0], mdio_i};
      bpos = bpos + 1;
      if (bpos == 36) phy_rd = (rec[1:0] == 2'b10);
      if (bpos == 64) begin
        bpos = 0;
        frames = frames + 1;
      end
    end
  end

  // PHY model: drives turnaround and data on the falling MDC edge of reads
  always @(negedge mdc) begin
    if (phy_rd && bpos == 47) begin
      drv = 1; drv_val = phy_err;
    end else if (phy_rd && bpos >= 48 && bpos <= 63) begin
      drv = 1; drv_val = phy_data[63-bpos];
    end else begin
      drv = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      brd(A_CFG, c);
      if (!c[31]) return;
    end
    chk(1'b0, "R3 busy never cleared", 64'd1, 64'd0);
  endtask

  function automatic logic [63:0] exp_frame(input logic r, input logic [4:0] p, input logic [4:0] g,
                                            input logic [15:0] w, input logic [15:0] pd, input logic e);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, (r ? {1'b1, e, pd} : {2'b10, w})};
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    int f0;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mdc == 0 && mdio_oe == 0 && mdio_o == 1, "R1 line idle", {mdc, mdio_oe, mdio_o}, 3'b001);
    rst = 0;
    brd(A_CFG, rv); chk(rv == 0, "R1 cfg", rv, 0);
    brd(A_CTL, rv); chk(rv == 0, "R1 ctl", rv, 0);
    brd(A_DAT, rv); chk(rv == 0, "R1 data", rv, 0);

    // vector table: R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic r; logic [4:0] p, g; logic [15:0] w, pd; logic e;
      {r, p, g, w, pd, e} = VEC[v];
      phy_data = pd; phy_err = e; f0 = frames;
      if (r) begin
        bwr(A_CTL, 32'h8000 | {p, g});
      end else begin
        bwr(A_CTL, {p, g});
        bwr(A_DAT, {16'hDEAD, w});
      end
      brd(A_CFG, rv); chk(rv[31] == 1, "R3 busy during frame", rv, 32'h8000_0000);
      wait_idle();
      chk(frames == f0 + 1, "R4/R5 one frame", frames, f0 + 1);
      chk(rec == exp_frame(r, p, g, w, pd, e), r ? "R4 read frame" : "R5 write frame",
          rec, exp_frame(r, p, g, w, pd, e));
      brd(A_DAT, rv);
      chk(rv == {16'd0, r ? pd : w}, r ? "R6 read data" : "R10 data readback", rv, {16'd0, r ? pd : w});
      if (r) begin
        brd(A_CFG, rv); chk(rv[1] == e, "R7 read error flag", rv[1], e);
      end
    end

    // R7: error flag cleared when next read starts
    phy_err = 1; phy_data = 16'h00F0;
    bwr(A_CTL, 32'h8000 | {5'd3, 5'd4}); wait_idle();
    brd(A_CFG, rv); chk(rv[1] == 1, "R7 set", rv[1], 1);
    phy_err = 0;
    bwr(A_CTL, 32'h8000 | {5'd3, 5'd4});
    brd(A_CFG, rv); chk(rv[1] == 0, "R7 cleared at read start", rv[1], 0);
    wait_idle();

    // R2: register map
    bwr(A_CTL, 32'hFFFF_7C00 | {5'd5, 5'd6});
    brd(A_CTL, rv); chk(rv == {22'd0, 5'd5, 5'd6}, "R2 ctl fields", rv, {22'd0, 5'd5, 5'd6});
    bwr(A_XR, 32'hCAFE_0123);
    brd(A_XR, rv); chk(rv == 32'hCAFE_0123, "R2 storage word", rv, 32'hCAFE_0123);
    brd(8'h40, rv); chk(rv == 0, "R2 unmapped", rv, 0);

    // R5: control write without read flag launches nothing
    f0 = frames;
    bwr(A_CTL, {5'd2, 5'd1});
    brd(A_CFG, rv); chk(rv[31] == 0, "R5 no launch busy", rv, 0);
    repeat (300) @(negedge clk);
    chk(frames == f0, "R5 no launch frame", frames, f0);

    // R11: clause 45 bit stored, frame unchanged
    bwr(A_CFG, 32'h0000_0040);
    brd(A_CFG, rv); chk(rv == 32'h40, "R11 c45 readback", rv, 32'h40);
    bwr(A_DAT, 32'h0000_3C3C); wait_idle();
    chk(rec == exp_frame(0, 5'd2, 5'd1, 16'h3C3C, 0, 0), "R11 frame unchanged",
        rec, exp_frame(0, 5'd2, 5'd1, 16'h3C3C, 0, 0));
    bwr(A_CFG, 0);

    // R8: writes during a frame are dropped
    f0 = frames;
    bwr(A_CTL, {5'd9, 5'd8});
    bwr(A_DAT, 32'h0000_1111);
    bwr(A_CTL, 32'h8000 | {5'd17, 5'd18});
    bwr(A_DAT, 32'h0000_2222);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R8 single frame", frames, f0 + 1);
    chk(rec == exp_frame(0, 5'd9, 5'd8, 16'h1111, 0, 0), "R8 first frame intact",
        rec, exp_frame(0, 5'd9, 5'd8, 16'h1111, 0, 0));
    brd(A_CTL, rv); chk(rv == {22'd0, 5'd9, 5'd8}, "R8 ctl kept", rv, {22'd0, 5'd9, 5'd8});
    brd(A_DAT, rv); chk(rv == 32'h1111, "R8 data kept", rv, 32'h1111);

    // R9: MDC period
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk((t1 - t0) == 5.0 * 2 * HALF, "R9 mdc period", longint'(t1 - t0), longint'(5.0 * 2 * HALF));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule